// File: doc/BRIEF.md
# Half-Bridge Channel Protection Sequencer

This block holds the timing and protection logic of a single power switch, either the low-side or the high-side device of a half-bridge. A committed on/off command drives the gate. Digital outcomes from an overcurrent comparator and an open-load comparator are qualified in time. The block then raises set pulses for the overload and underload flags that sit elsewhere in the chip. Twelve copies, one for each switch, share the serial interface's commit strobe, the overcurrent-lockout enable and a one-microsecond tick.

Overcurrent must persist for a dead time before the gate is cut. The cut happens only while software keeps the lockout enabled. With the lockout disabled, the switch stays on under external current limiting, which lets inrush loads start. Every commit strobe restarts an underload blanking window, so commutation transients that follow a new command are not reported. A low-side channel waits a turn-on delay after its command rises, so that its high-side partner has already released. The reported status is the measured gate state, not the command. Active-low reset models inhibit and power-on reset, and it forces the gate off.

Top module: `chan_guard`

## Requirements
- R1: While rst_n is low, gate_en, gate_status, ovl_set and unl_set are all 0, whatever cmd_on is.
- R2: With LOW_SIDE = 0 and no cutoff latched, gate_en equals the cmd_on value sampled on the previous clock edge.
- R3: With LOW_SIDE = 1, gate_en rises one clock after LS_DELAY_US ticks have been counted since cmd_on went high. It falls one clock after cmd_on goes low.
- R4: While gate_en, oc_in and lock_en are all 1 over OC_DEAD_US consecutive ticks, ovl_set pulses high for exactly one clock and gate_en goes to 0 on the following clock.
- R5: A clock with oc_in low (or lock_en low, or gate off) clears the overcurrent time, so a full OC_DEAD_US further ticks are needed before a cutoff.
- R6: While lock_en is 0, overcurrent never raises ovl_set and never switches the gate off.
- R7: After a cutoff, gate_en stays 0 for as long as cmd_on stays 1, commits included. It returns only after cmd_on has been low and then high again.
- R8: Each commit pulse starts an underload blanking window of UL_BLANK_US ticks. Open load inside that window never raises unl_set.
- R9: Outside the blanking window, unl_set is 1 in the clock after each clock where gate_en and ol_in are both 1.
- R10: gate_status is gate_en delayed by one clock, so a channel cut off by overcurrent reads as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low inhibit / power-on reset, asynchronous |
| tick_us | input | 1 | One-clock pulse every microsecond |
| commit | input | 1 | One-clock pulse at the interface commit edge |
| cmd_on | input | 1 | Committed on/off command for this switch |
| lock_en | input | 1 | Overcurrent lockout enable (1 = cut off after dead time) |
| oc_in | input | 1 | Overcurrent comparator outcome |
| ol_in | input | 1 | Open-load comparator outcome |
| gate_en | output | 1 | Gate drive enable (0 = output released) |
| gate_status | output | 1 | Measured on/off state of the gate |
| ovl_set | output | 1 | Set pulse for the overload flag |
| unl_set | output | 1 | Set pulse for the underload flag |

## Verification
The assertions check the following on every cycle:
- an overload pulse is always followed by a gate that is off, and the pulse never lasts two clocks;
- the overcurrent timer stays inside its dead time;
- a latched cutoff keeps the gate off while the command stays high;
- a low-side gate only rises once its delay has elapsed;
- a commit always opens blanking;
- status and underload pulses only follow a gate that was on.

Only the bench scenarios can show the time-dependent behaviour. This covers the exact dead-time length, the overcurrent timer restarting after a dropout, and the lockout-disabled case riding through a long overcurrent. It also covers the re-arm sequence through a low command and the blanking window restarting on a second commit.

// File: rtl/chan_guard_pkg.sv
`timescale 1ns/1ps
package chan_guard_pkg;

  // Counter width able to hold values 0..n
  function automatic int span_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True on the tick that completes a window of 'limit' ticks
  function automatic logic window_done(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/cg_turnon_delay.sv
`timescale 1ns/1ps
module cg_turnon_delay
  import chan_guard_pkg::*;
#(
  parameter int DELAY_US = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic tick_us,
  output logic ready
);
  localparam int CW = span_bits(DELAY_US);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!cmd_on) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q && tick_us) begin
      if (window_done(32'(cnt_q), DELAY_US)) ready_q <= 1'b1;
      else                                   cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready = ready_q;

  // R3: ready never survives a low command
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> !ready_q);

endmodule

// File: rtl/cg_oc_watch.sv
`timescale 1ns/1ps
module cg_oc_watch
  import chan_guard_pkg::*;
#(
  parameter int DEAD_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic cmd_on,
  input  logic gate_on,
  input  logic oc_in,
  input  logic lock_en,
  output logic tripped,
  output logic trip_pulse
);
  localparam int CW = span_bits(DEAD_US);

  logic [CW-1:0] cnt_q;
  logic          trip_q, pulse_q;
  logic          oc_run, fire;

  assign oc_run = gate_on & oc_in & lock_en;
  assign fire   = oc_run & tick_us & window_done(32'(cnt_q), DEAD_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trip_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      trip_q  <= cmd_on & (trip_q | fire);
      if (!oc_run || fire) cnt_q <= '0;
      else if (tick_us)    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tripped    = trip_q;
  assign trip_pulse = pulse_q;

  // R5: the dwell timer stays inside the dead time
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < DEAD_US);

  // R5: a dropout of the overcurrent clears the timer
  a_r5_dropout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_in |=> (cnt_q == '0));

  // R4: an overload pulse lasts a single clock
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

endmodule

// File: rtl/cg_blank_timer.sv
`timescale 1ns/1ps
module cg_blank_timer
  import chan_guard_pkg::*;
#(
  parameter int BLANK_US = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic commit,
  output logic blanking
);
  localparam int CW = span_bits(BLANK_US);

  logic [CW-1:0] cnt_q;
  logic          blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= 1'b0;
    end else if (commit) begin
      cnt_q   <= '0;
      blank_q <= 1'b1;
    end else if (blank_q && tick_us) begin
      if (window_done(32'(cnt_q), BLANK_US)) begin
        cnt_q   <= '0;
        blank_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign blanking = blank_q;

  // R8: a commit always opens the blanking window
  a_r8_commit_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> blank_q);

  // R8: the window only ends on a tick
  a_r8_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_q) |-> $past(tick_us));

endmodule

// File: rtl/chan_guard.sv
`timescale 1ns/1ps
module chan_guard #(
  parameter bit LOW_SIDE    = 1'b1,
  parameter int OC_DEAD_US  = 50,
  parameter int UL_BLANK_US = 300,
  parameter int LS_DELAY_US = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic commit,
  input  logic cmd_on,
  input  logic lock_en,
  input  logic oc_in,
  input  logic ol_in,
  output logic gate_en,
  output logic gate_status,
  output logic ovl_set,
  output logic unl_set
);
  logic on_ready;
  logic tripped, trip_pulse;
  logic blanking;
  logic gate_q, stat_q, unl_q;

  generate
    if (LOW_SIDE) begin : g_low
      cg_turnon_delay #(.DELAY_US(LS_DELAY_US)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_on (cmd_on),
        .tick_us(tick_us),
        .ready  (on_ready)
      );
    end else begin : g_high
      assign on_ready = 1'b1;
    end
  endgenerate

  cg_oc_watch #(.DEAD_US(OC_DEAD_US)) u_oc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .cmd_on    (cmd_on),
    .gate_on   (gate_q),
    .oc_in     (oc_in),
    .lock_en   (lock_en),
    .tripped   (tripped),
    .trip_pulse(trip_pulse)
  );

  cg_blank_timer #(.BLANK_US(UL_BLANK_US)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_us (tick_us),
    .commit  (commit),
    .blanking(blanking)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      stat_q <= 1'b0;
      unl_q  <= 1'b0;
    end else begin
      gate_q <= cmd_on & on_ready & ~tripped;
      stat_q <= gate_q;
      unl_q  <= gate_q & ol_in & ~blanking;
    end
  end

  assign gate_en     = gate_q;
  assign gate_status = stat_q;
  assign ovl_set     = trip_pulse;
  assign unl_set     = unl_q;

  // R4: an overload report is followed by the gate switching off
  a_r4_cut_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_set |=> !gate_en);

  // R6: no overload report unless the lockout was enabled
  a_r6_lock_needed: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_set |-> $past(lock_en));

  // R7: a latched cutoff holds the gate off while the command stays high
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && cmd_on) |=> !gate_en);

  // R3: a gate rise needs the turn-on delay to be complete
  a_r3_rise_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> on_ready);

  // R9: an underload report needs a driven gate outside blanking
  a_r9_unl_cause: assert property (@(posedge clk) disable iff (!rst_n)
    unl_set |-> ($past(gate_q) && $past(!blanking)));

  // R10: the status follows the gate state
  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    gate_status |-> $past(gate_en));

endmodule

// File: tb/chan_guard_test.sv
`timescale 1ns/1ps
module chan_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 2;
  localparam int OCD  = 50;
  localparam int UBL  = 300;
  localparam int LSD  = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, commit = 1'b0;
  logic cmd_on = 1'b0, lock_en = 1'b0, oc_in = 1'b0, ol_in = 1'b0;
  logic ls_gate, ls_stat, ls_ovl, ls_unl;
  logic hs_gate, hs_stat, hs_ovl, hs_unl;

  int errors = 0, checks = 0;
  int ovl_n[2], unl_n[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_guard #(.LOW_SIDE(1'b1), .OC_DEAD_US(OCD), .UL_BLANK_US(UBL), .LS_DELAY_US(LSD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .commit(commit), .cmd_on(cmd_on),
    .lock_en(lock_en), .oc_in(oc_in), .ol_in(ol_in),
    .gate_en(ls_gate), .gate_status(ls_stat), .ovl_set(ls_ovl), .unl_set(ls_unl));

  chan_guard #(.LOW_SIDE(1'b0), .OC_DEAD_US(OCD), .UL_BLANK_US(UBL), .LS_DELAY_US(LSD)) uut_hs (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .commit(commit), .cmd_on(cmd_on),
    .lock_en(lock_en), .oc_in(oc_in), .ol_in(ol_in),
    .gate_en(hs_gate), .gate_status(hs_stat), .ovl_set(hs_ovl), .unl_set(hs_unl));

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // microsecond tick, driven just after the edge
  int tcnt = 0;
  always @(posedge clk) begin
    #1;
    if (tcnt == TDIV - 1) begin tcnt = 0; tick_us = 1'b1; end
    else begin tcnt++; tick_us = 1'b0; end
  end

  // ---------------- behavioural expectation (index 0 = high, 1 = low) ----------
  int m_rdy[2], m_oct[2], m_left;
  bit m_gate[2], m_trip[2], m_stat[2], m_ovl[2], m_unl[2];

  function automatic bit side_ready(input int s, input int ticks_seen);
    return (s == 0) ? 1'b1 : (ticks_seen >= LSD);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0;
      for (int s = 0; s < 2; s++) begin
        m_rdy[s] = 0; m_oct[s] = 0; m_gate[s] = 0; m_trip[s] = 0;
        m_stat[s] = 0; m_ovl[s] = 0; m_unl[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        bit run, fire, ngate;
        int noct;
        run  = m_gate[s] && oc_in && lock_en;
        fire = 1'b0;
        noct = m_oct[s];
        if (!run) noct = 0;
        else if (tick_us) begin
          if (m_oct[s] + 1 == OCD) begin fire = 1'b1; noct = 0; end
          else noct = m_oct[s] + 1;
        end
        ngate     = cmd_on && side_ready(s, m_rdy[s]) && !m_trip[s];
        m_unl[s]  = m_gate[s] && ol_in && (m_left == 0);
        m_stat[s] = m_gate[s];
        m_ovl[s]  = fire;
        m_trip[s] = cmd_on ? (m_trip[s] | fire) : 1'b0;
        m_oct[s]  = noct;
        if (!cmd_on) m_rdy[s] = 0;
        else if (tick_us && m_rdy[s] < LSD) m_rdy[s]++;
        m_gate[s] = ngate;
      end
      if (commit) m_left = UBL;
      else if (tick_us && m_left > 0) m_left--;
    end
  end

  // continuous comparison and event counting, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      expect_eq("R2", "hs gate_en", hs_gate, m_gate[0]);
      expect_eq("R3", "ls gate_en", ls_gate, m_gate[1]);
      expect_eq("R10", "hs gate_status", hs_stat, m_stat[0]);
      expect_eq("R10", "ls gate_status", ls_stat, m_stat[1]);
      expect_eq("R4", "hs ovl_set", hs_ovl, m_ovl[0]);
      expect_eq("R4", "ls ovl_set", ls_ovl, m_ovl[1]);
      expect_eq("R9", "hs unl_set", hs_unl, m_unl[0]);
      expect_eq("R9", "ls unl_set", ls_unl, m_unl[1]);
      if (hs_ovl) ovl_n[0]++;
      if (ls_ovl) ovl_n[1]++;
      if (hs_unl) unl_n[0]++;
      if (ls_unl) unl_n[1]++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_cmd(input bit v);
    cmd_on = v;
    commit = 1'b1;
    cycles(1);
    commit = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base_o0, base_o1, base_u0, base_u1, r;
    r = $urandom(32'd4711);
    ovl_n = '{0, 0}; unl_n = '{0, 0};

    // R1: reset forces everything off even with the command high
    cmd_on = 1'b1;
    cycles(6);
    @(negedge clk);
    expect_eq("R1", "ls gate_en in reset", ls_gate, 0);
    expect_eq("R1", "hs gate_en in reset", hs_gate, 0);
    expect_eq("R1", "gate_status in reset", ls_stat | hs_stat, 0);
    expect_eq("R1", "set pulses in reset", ls_ovl | hs_ovl | ls_unl | hs_unl, 0);
    cycles(1);
    cmd_on = 1'b0;
    rst_n  = 1'b1;
    lock_en = 1'b1;
    cycles(3);

    // R2 / R3: turn-on timing
    write_cmd(1'b1);
    @(negedge clk);
    expect_eq("R2", "hs on one clock after command", hs_gate, 1);
    expect_eq("R3", "ls still waiting", ls_gate, 0);
    cycles(5);
    @(negedge clk);
    expect_eq("R3", "ls off before delay", ls_gate, 0);
    cycles(10);
    @(negedge clk);
    expect_eq("R3", "ls on after delay", ls_gate, 1);

    // R8: open load inside blanking is not reported
    base_u0 = unl_n[0]; base_u1 = unl_n[1];
    cycles(200);
    ol_in = 1'b1;
    cycles(20);
    ol_in = 1'b0;
    @(negedge clk);
    expect_eq("R8", "no underload while blanked", unl_n[0] + unl_n[1] - base_u0 - base_u1, 0);

    // R9: after the window open load is reported
    cycles(450);
    ol_in = 1'b1;
    cycles(4);
    @(negedge clk);
    expect_eq("R9", "hs underload after window", hs_unl, 1);
    expect_eq("R9", "ls underload after window", ls_unl, 1);
    ol_in = 1'b0;
    cycles(2);

    // R8: a second commit restarts blanking
    write_cmd(1'b1);
    base_u0 = unl_n[0]; base_u1 = unl_n[1];
    ol_in = 1'b1;
    cycles(100);
    ol_in = 1'b0;
    @(negedge clk);
    expect_eq("R8", "recommit blanks again", unl_n[0] + unl_n[1] - base_u0 - base_u1, 0);
    cycles(2);

    // R5: dropout restarts the overcurrent time
    base_o0 = ovl_n[0]; base_o1 = ovl_n[1];
    oc_in = 1'b1;
    cycles(60);
    oc_in = 1'b0;
    cycles(2);
    oc_in = 1'b1;
    cycles(60);
    @(negedge clk);
    expect_eq("R5", "no cutoff after split overcurrent", ovl_n[0] + ovl_n[1] - base_o0 - base_o1, 0);
    expect_eq("R5", "gates still on", hs_gate & ls_gate, 1);

    // R4 / R10: continuous overcurrent trips
    cycles(50);
    @(negedge clk);
    expect_eq("R4", "hs one overload pulse", ovl_n[0] - base_o0, 1);
    expect_eq("R4", "ls one overload pulse", ovl_n[1] - base_o1, 1);
    expect_eq("R4", "gates cut", hs_gate | ls_gate, 0);
    expect_eq("R10", "status reads off after cutoff", hs_stat | ls_stat, 0);

    // R7: stays off until command low then high
    cycles(40);
    oc_in = 1'b0;
    write_cmd(1'b1);
    cycles(20);
    @(negedge clk);
    expect_eq("R7", "still off after recommit high", hs_gate | ls_gate, 0);
    expect_eq("R7", "no further overload", ovl_n[0] - base_o0, 1);
    write_cmd(1'b0);
    cycles(4);
    write_cmd(1'b1);
    cycles(20);
    @(negedge clk);
    expect_eq("R7", "hs rearmed", hs_gate, 1);
    expect_eq("R7", "ls rearmed", ls_gate, 1);

    // R6: lockout disabled rides through overcurrent
    base_o0 = ovl_n[0]; base_o1 = ovl_n[1];
    lock_en = 1'b0;
    oc_in = 1'b1;
    cycles(300);
    @(negedge clk);
    expect_eq("R6", "gates kept on", hs_gate & ls_gate, 1);
    expect_eq("R6", "no overload report", ovl_n[0] + ovl_n[1] - base_o0 - base_o1, 0);
    oc_in = 1'b0;
    lock_en = 1'b1;
    cycles(4);

    // mixed random stimulus against the expectation model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 150 == 0) begin
        cmd_on = 1'($urandom % 2);
        commit = 1'b1;
      end else begin
        commit = 1'b0;
      end
      if ($urandom % 40 == 0)  oc_in   = ~oc_in;
      if ($urandom % 25 == 0)  ol_in   = ~ol_in;
      if ($urandom % 700 == 0) lock_en = ~lock_en;
      cycles(1);
    end
    commit = 1'b0;

    // R1: reset in mid operation
    cmd_on = 1'b1;
    rst_n  = 1'b0;
    cycles(2);
    @(negedge clk);
    expect_eq("R1", "late reset clears gates", hs_gate | ls_gate | hs_stat | ls_stat, 0);
    cycles(1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule